// File: doc/BRIEF.md
# Packet Page Manager

This block owns a small packet RAM and deals it out one page per packet from a single pool that the receive side and software transmit side both draw from; neither side has a reserved share. Every page carries a 3-bit packet number, the index of the page itself, so the RAM holds only packet bytes. No links or descriptors are stored in it.

Packet numbers move through three FIFOs: packets queued for transmission, packets whose transmission has completed, and packets that have been received. Software issues single-cycle commands to allocate, queue, drop or free packets. It reaches packet bytes through one data port whose byte pointer it may set to any offset and which steps by one on every access. The MAC side asks for receive pages, commits received packets, takes transmit packets and reports completions through plain strobes.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset every page is free (`free_map` = 8'hFF), all three queues are empty, and `alloc_done` and `alloc_fail` are low.
- R2: A software allocate command (`cmd_op` = 1) grants the lowest-numbered free page. `alloc_done` rises and `alloc_pkt` holds the page two clock edges after the command edge, and the page's bit in `free_map` is cleared.
- R3: While `rx_alloc_req` is high, `rx_alloc_ok` and `rx_alloc_pkt` show in the same cycle whether a page is free and which is lowest. That page is marked used at the next edge. A receive request takes priority over a pending software grant in the same cycle, and both sides draw on the same pages.
- R4: If no page is free, `alloc_fail` is high from the edge after the allocate command. The request stays pending, and the edge after a page becomes free grants it, raising `alloc_done` and dropping `alloc_fail`.
- R5: Each queue (transmit: push by command 2, pop by `tx_take`; done: push by `tx_complete`, pop by command 3; receive: push by `rx_commit`, pop by commands 4 or 5) returns numbers in FIFO order and holds 8 entries. A push to a full queue and a pop from an empty queue are ignored.
- R6: Command 5 pops the receive head and frees its page at the same edge. Command 4 pops without freeing.
- R7: Command 6 frees page `cmd_pkt` at the next edge.
- R8: Command 7 loads the byte pointer from `cmd_arg[7:0]` and the read mode from `cmd_arg[8]`. Mode 1 addresses the receive head page and mode 0 addresses page `cmd_pkt`. Each `dp_wr` or `dp_rd` cycle advances the pointer by one, wrapping inside the page, and read data appears on `dp_rdata` at the edge of the read.
- R9: While an allocation is failing, received packets can still be popped and their bytes read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 alloc, 2 queue tx, 3 pop done, 4 rx drop, 5 rx drop+free, 6 free, 7 set pointer |
| cmd_pkt | input | 3 | Packet number operand |
| cmd_arg | input | 9 | Pointer offset [7:0] and read mode [8] |
| alloc_pkt | output | 3 | Page granted to software |
| alloc_done | output | 1 | Software grant done, cleared by the next allocate |
| alloc_fail | output | 1 | Allocate pending with no free page |
| free_map | output | 8 | One bit per page, 1 = free |
| rx_alloc_req | input | 1 | Receive side takes a page this cycle |
| rx_alloc_ok | output | 1 | A page is free |
| rx_alloc_pkt | output | 3 | Page the receive side would get |
| rx_commit | input | 1 | Push `rx_commit_pkt` on the receive queue |
| rx_commit_pkt | input | 3 | Received packet number |
| rx_head | output | 3 | Receive queue head |
| rx_empty | output | 1 | Receive queue empty |
| tx_take | input | 1 | Pop the transmit queue |
| tx_head | output | 3 | Transmit queue head |
| tx_empty | output | 1 | Transmit queue empty |
| tx_complete | input | 1 | Push `tx_complete_pkt` on the done queue |
| tx_complete_pkt | input | 3 | Completed packet number |
| done_head | output | 3 | Done queue head |
| done_empty | output | 1 | Done queue empty |
| dp_wr | input | 1 | Write `dp_wdata` at the pointer |
| dp_wdata | input | 8 | Write byte |
| dp_rd | input | 1 | Read at the pointer |
| dp_rdata | output | 8 | Read byte |

## Verification
The receive grant is combinational, so it is checked in the cycle of the request. Bitmap, queue and pointer changes, and read data, are due one edge after their stimulus. A software grant is due two edges after its command, because the command first sets a pending flag. Every stimulus is held across exactly one rising edge, and the bench samples 1 ns after the edge at which each result is due. For grants it waits the extra edge before sampling.

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr #(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 256,
  parameter int QDEPTH     = 8,
  parameter int DW         = 8,
  localparam int PW        = $clog2(PAGES),
  localparam int OFFW      = $clog2(PAGE_BYTES),
  localparam int QW        = $clog2(QDEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [PW-1:0]   cmd_pkt,
  input  logic [OFFW:0]   cmd_arg,
  output logic [PW-1:0]   alloc_pkt,
  output logic            alloc_done,
  output logic            alloc_fail,
  output logic [PAGES-1:0] free_map,
  input  logic            rx_alloc_req,
  output logic            rx_alloc_ok,
  output logic [PW-1:0]   rx_alloc_pkt,
  input  logic            rx_commit,
  input  logic [PW-1:0]   rx_commit_pkt,
  output logic [PW-1:0]   rx_head,
  output logic            rx_empty,
  input  logic            tx_take,
  output logic [PW-1:0]   tx_head,
  output logic            tx_empty,
  input  logic            tx_complete,
  input  logic [PW-1:0]   tx_complete_pkt,
  output logic [PW-1:0]   done_head,
  output logic            done_empty,
  input  logic            dp_wr,
  input  logic [DW-1:0]   dp_wdata,
  input  logic            dp_rd,
  output logic [DW-1:0]   dp_rdata
);
  localparam logic [2:0] OP_ALLOC = 3'd1, OP_ENQ = 3'd2, OP_POPD = 3'd3,
                         OP_DROP = 3'd4, OP_FREE = 3'd5, OP_REL = 3'd6, OP_PTR = 3'd7;
  localparam int NQ = 3;
  localparam int AW = PW + OFFW;

  function automatic logic is_op(input logic [2:0] op);
    return cmd_valid && cmd_op == op;
  endfunction

  // packet-number queues: 0 transmit, 1 done, 2 receive
  logic [NQ-1:0] q_push, q_pop, q_empty, q_full;
  logic [PW-1:0] q_din [NQ];
  logic [PW-1:0] q_head [NQ];

  assign q_push   = {rx_commit, tx_complete, is_op(OP_ENQ)};
  assign q_pop    = {is_op(OP_DROP) || is_op(OP_FREE), is_op(OP_POPD), tx_take};
  assign q_din[0] = cmd_pkt;
  assign q_din[1] = tx_complete_pkt;
  assign q_din[2] = rx_commit_pkt;

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_q
      logic [PW-1:0] mem [QDEPTH];
      logic [QW:0]   wp, rp;
      assign q_empty[g] = (wp == rp);
      assign q_full[g]  = (wp[QW] != rp[QW]) && (wp[QW-1:0] == rp[QW-1:0]);
      assign q_head[g]  = mem[rp[QW-1:0]];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          wp <= '0;
          rp <= '0;
        end else begin
          if (q_push[g] && !q_full[g])  wp <= wp + 1'b1;
          if (q_pop[g]  && !q_empty[g]) rp <= rp + 1'b1;
        end
      always_ff @(posedge clk)
        if (q_push[g] && !q_full[g]) mem[wp[QW-1:0]] <= q_din[g];

      assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wp - rp) <= (QW+1)'(QDEPTH));
    end
  endgenerate

  assign tx_head = q_head[0];  assign tx_empty   = q_empty[0];
  assign done_head = q_head[1]; assign done_empty = q_empty[1];
  assign rx_head = q_head[2];  assign rx_empty   = q_empty[2];

  // page bitmap and allocation
  logic [PW-1:0]    low_idx;
  logic             any_free, alloc_pend, grant, take, rel_en;
  logic [PW-1:0]    rel_pg;
  logic [PAGES-1:0] free_nxt;

  always_comb begin
    low_idx = '0;
    for (int i = PAGES-1; i >= 0; i--)
      if (free_map[i]) low_idx = PW'(i);
  end

  assign any_free     = |free_map;
  assign grant        = alloc_pend && any_free && !rx_alloc_req;
  assign take         = any_free && (rx_alloc_req || grant);
  assign rel_en       = is_op(OP_REL) || (is_op(OP_FREE) && !q_empty[2]);
  assign rel_pg       = is_op(OP_REL) ? cmd_pkt : q_head[2];
  assign rx_alloc_ok  = any_free;
  assign rx_alloc_pkt = low_idx;
  assign alloc_fail   = alloc_pend && !any_free;

  always_comb begin
    free_nxt = free_map;
    if (rel_en) free_nxt[rel_pg]  = 1'b1;
    if (take)   free_nxt[low_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      free_map   <= '1;
      alloc_pend <= 1'b0;
      alloc_done <= 1'b0;
      alloc_pkt  <= '0;
    end else begin
      free_map <= free_nxt;
      if (grant) begin
        alloc_pend <= 1'b0;
        alloc_done <= 1'b1;
        alloc_pkt  <= low_idx;
      end else if (is_op(OP_ALLOC) && !alloc_pend) begin
        alloc_pend <= 1'b1;
        alloc_done <= 1'b0;
      end
    end

  assert_grant_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_done) |-> !free_map[alloc_pkt]);
  assert_rx_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_alloc_req && rx_alloc_ok |=> !free_map[$past(rx_alloc_pkt)]);
  assert_rx_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_alloc_req |=> !$rose(alloc_done));

  // data port
  logic [OFFW-1:0] ptr;
  logic            rd_mode;
  logic [PW-1:0]   tx_sel;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   ram [PAGES*PAGE_BYTES];

  assign addr = {rd_mode ? q_head[2] : tx_sel, ptr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr     <= '0;
      rd_mode <= 1'b0;
      tx_sel  <= '0;
    end else if (is_op(OP_PTR)) begin
      ptr     <= cmd_arg[OFFW-1:0];
      rd_mode <= cmd_arg[OFFW];
      tx_sel  <= cmd_pkt;
    end else if (dp_rd || dp_wr) begin
      ptr <= ptr + 1'b1;
    end

  always_ff @(posedge clk) begin
    if (dp_wr) ram[addr] <= dp_wdata;
    if (dp_rd) dp_rdata  <= ram[addr];
  end

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd || dp_wr) && !is_op(OP_PTR) |=> ptr == OFFW'($past(ptr) + 1'b1));
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_rd && !dp_wr && !is_op(OP_PTR) |=> $stable(ptr));
endmodule

// File: tb/pkt_page_mgr_tb_top.sv
`timescale 1ns/1ps
module pkt_page_mgr_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0; logic [2:0] cmd_op = 0; logic [2:0] cmd_pkt = 0; logic [8:0] cmd_arg = 0;
  logic [2:0] alloc_pkt, rx_alloc_pkt, rx_head, tx_head, done_head;
  logic alloc_done, alloc_fail, rx_alloc_ok, rx_empty, tx_empty, done_empty;
  logic [7:0] free_map, dp_rdata;
  logic rx_alloc_req = 0, rx_commit = 0, tx_take = 0, tx_complete = 0, dp_wr = 0, dp_rd = 0;
  logic [2:0] rx_commit_pkt = 0, tx_complete_pkt = 0;
  logic [7:0] dp_wdata = 0;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  localparam logic [2:0] ALLOC = 1, ENQ = 2, POPD = 3, DROP = 4, FREE = 5, REL = 6, PTR = 7;

  always #2.5 clk = ~clk;

  pkt_page_mgr dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] pkt, input logic [8:0] arg);
    cmd_valid = 1; cmd_op = op; cmd_pkt = pkt; cmd_arg = arg;
    tick();
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic rx_get(); rx_alloc_req = 1; tick(); rx_alloc_req = 0; endtask
  task automatic rx_put(input logic [2:0] p); rx_commit = 1; rx_commit_pkt = p; tick(); rx_commit = 0; endtask
  task automatic take(); tx_take = 1; tick(); tx_take = 0; endtask
  task automatic wr(input logic [7:0] d); dp_wr = 1; dp_wdata = d; tick(); dp_wr = 0; endtask
  task automatic rd(); dp_rd = 1; tick(); dp_rd = 0; endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(posedge clk); #1; rst_n = 1; tick();
  endtask

  // kind(2) 0 sw alloc, 1 rx alloc, 2 release | pkt(3) | expected pkt(3) | expected map(8)
  localparam logic [15:0] VEC [8] = '{
    {2'd1, 3'd0, 3'd0, 8'hFE}, {2'd0, 3'd0, 3'd1, 8'hFC},
    {2'd1, 3'd0, 3'd2, 8'hF8}, {2'd2, 3'd1, 3'd0, 8'hFA},
    {2'd0, 3'd0, 3'd1, 8'hF8}, {2'd1, 3'd0, 3'd3, 8'hF0},
    {2'd2, 3'd0, 3'd0, 8'hF1}, {2'd1, 3'd0, 3'd0, 8'hF0}};

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 free_map", free_map, 8'hFF);
    chk("R1 empties", {tx_empty, done_empty, rx_empty}, 3'b111);
    chk("R1 alloc flags", {alloc_done, alloc_fail}, 2'b00);

    // shared pool walk: R2 R3 R7
    for (int i = 0; i < 8; i++) begin
      case (VEC[i][15:14])
        2'd0: begin
          cmd(ALLOC, 0, 0); tick();
          chk("R2 alloc_done", alloc_done, 1);
          chk("R2 alloc_pkt", alloc_pkt, VEC[i][10:8]);
        end
        2'd1: begin
          rx_alloc_req = 1; #1;
          chk("R3 rx_alloc_pkt", {rx_alloc_ok, rx_alloc_pkt}, {1'b1, VEC[i][10:8]});
          @(posedge clk); #1; rx_alloc_req = 0;
        end
        default: cmd(REL, VEC[i][13:11], 0);
      endcase
      chk("R2 R3 R7 free_map", free_map, VEC[i][7:0]);
    end

    // R3 receive request beats pending software grant
    do_reset();
    cmd(ALLOC, 0, 0);
    rx_get();
    chk("R3 priority done", alloc_done, 0);
    chk("R3 priority map", free_map, 8'hFE);
    tick();
    chk("R3 sw after rx", {alloc_done, alloc_pkt}, {1'b1, 3'd1});

    // R4 R6 R9 exhaustion
    do_reset();
    for (int i = 0; i < 8; i++) rx_get();
    chk("R3 pool empty", {rx_alloc_ok, free_map}, 9'h000);
    rx_put(5); rx_put(2);
    cmd(ALLOC, 0, 0);
    chk("R4 alloc_fail", alloc_fail, 1);
    cmd(DROP, 0, 0);
    chk("R9 rx pops while failing", {rx_empty, rx_head}, {1'b0, 3'd2});
    chk("R6 drop keeps page", {free_map, alloc_fail}, {8'h00, 1'b1});
    cmd(FREE, 0, 0);
    chk("R6 free releases head", {free_map, rx_empty, alloc_fail}, {8'h04, 1'b1, 1'b0});
    tick();
    chk("R4 late grant", {alloc_done, alloc_pkt, free_map}, {1'b1, 3'd2, 8'h00});
    cmd(REL, 6, 0);
    chk("R7 release", free_map, 8'h40);

    // R5 queue order
    do_reset();
    cmd(ENQ, 3, 0); cmd(ENQ, 1, 0); cmd(ENQ, 4, 0);
    chk("R5 tx head", tx_head, 3);
    take(); chk("R5 tx second", tx_head, 1);
    take(); chk("R5 tx third", tx_head, 4);
    take(); chk("R5 tx empty", tx_empty, 1);
    tx_complete = 1; tx_complete_pkt = 1; tick(); tx_complete_pkt = 4; tick(); tx_complete = 0;
    chk("R5 done head", {done_empty, done_head}, {1'b0, 3'd1});
    cmd(POPD, 0, 0);
    chk("R5 done second", done_head, 4);

    // R5 full and empty limits
    for (int i = 0; i < 9; i++) cmd(ENQ, (i == 8) ? 3'd5 : 3'(i), 0);
    for (int i = 0; i < 8; i++) begin
      chk("R5 fill order", {tx_empty, tx_head}, {1'b0, 3'(i)});
      take();
    end
    chk("R5 push to full ignored", tx_empty, 1);
    take();
    cmd(ENQ, 2, 0);
    chk("R5 pop of empty ignored", {tx_empty, tx_head}, {1'b0, 3'd2});
    take();
    chk("R5 single entry", tx_empty, 1);

    // R8 data port
    do_reset();
    rx_get();
    cmd(PTR, 0, 9'h000);
    wr(8'hA0); wr(8'hA1); wr(8'hA2); wr(8'hA3);
    rx_put(0);
    cmd(PTR, 0, 9'h102);
    rd(); chk("R8 offset read", dp_rdata, 8'hA2);
    rd(); chk("R8 auto increment", dp_rdata, 8'hA3);
    cmd(PTR, 1, 9'h0FF);
    wr(8'h55); wr(8'h66);
    cmd(PTR, 1, 9'h000);
    rd(); chk("R8 wrap in page", dp_rdata, 8'h66);
    cmd(PTR, 1, 9'h0FF);
    rd(); chk("R8 last byte", dp_rdata, 8'h55);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule